// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive byte stream of an Ethernet MAC and decides, from the destination address at the head of each frame, whether the frame is kept. It collects the first six bytes after a start-of-frame marker and runs a serial CRC-32 over them as they arrive. Once the address is complete, or the frame ends before that, it issues a single registered decision with two flags: accept and miss.

Each frame takes one of four paths. An all-ones address is broadcast and follows a reject mode bit. An address whose first byte has its group bit set goes through a 64-entry hash table. With the hash-all mode on, individual addresses also go through the hash table. Any other address is compared exactly against a 48-bit station address. In promiscuous mode every frame is accepted, and the miss flag still reports whether the filter would have matched.

Top module: `dafilt_top`

## Requirements
- R1: A destination of six 0xFF bytes is broadcast. Its miss flag equals `mode_bcast_reject`. Broadcast takes precedence over the hash and exact paths.
- R2: A non-broadcast destination whose first byte has bit 0 set is looked up in the hash table, and miss is the inverse of the selected hash bit.
- R3: With `mode_hash_all` high, a non-broadcast destination whose first byte has bit 0 clear also uses the hash lookup instead of the exact compare.
- R4: On the exact path, miss is 0 only when the address matches `stn_hi`/`stn_lo`. The match requires byte 0 = `stn_hi[15:8]`, byte 1 = `stn_hi[7:0]`, byte 2 = `stn_lo[31:24]`, byte 3 = `stn_lo[23:16]`, byte 4 = `stn_lo[15:8]` and byte 5 = `stn_lo[7:0]`, where byte 0 is the first byte received.
- R5: The hash index is CRC bits 31:26. The CRC uses polynomial 0x04C11DB7, starts from all ones, takes each byte least-significant bit first over the six address bytes, and has no final inversion. Index values 0..31 select `hash_lo[index]`; values 32..63 select `hash_hi[index-32]`.
- R6: A frame whose `in_last` byte arrives before the sixth byte is a miss.
- R7: `dec_accept` equals NOT miss OR `mode_promisc`. In promiscuous mode the miss flag is still reported.
- R8: `dec_valid` is a one-cycle pulse in the cycle after the clock edge that samples the sixth byte, or the early last byte. Each frame gives exactly one decision, and bytes after the sixth have no effect. `dec_accept` and `dec_miss` are 0 whenever `dec_valid` is 0.
- R9: `in_sof` restarts collection and discards any unfinished frame. Valid bytes that arrive while no frame is open are ignored.
- R10: After reset, `dec_valid`, `dec_accept` and `dec_miss` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte strobe |
| in_sof | input | 1 | First byte of a frame, qualified by in_valid |
| in_last | input | 1 | Final byte of a frame, qualified by in_valid |
| in_data | input | 8 | Received byte |
| mode_bcast_reject | input | 1 | Broadcast frames count as miss |
| mode_promisc | input | 1 | Accept every frame, keeping the miss flag |
| mode_hash_all | input | 1 | Individual addresses also use the hash table |
| stn_hi | input | 16 | Station address bytes 0 and 1 |
| stn_lo | input | 32 | Station address bytes 2 to 5 |
| hash_lo | input | 32 | Hash bits for indices 0..31 |
| hash_hi | input | 32 | Hash bits for indices 32..63 |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame is accepted |
| dec_miss | output | 1 | Address did not pass the filter |

## Verification
The assertions assume that the mode bits, station address and hash table are held steady while a frame's address is being collected. They also assume that `in_sof` and `in_last` are only meaningful together with `in_valid`. The stimulus changes configuration only between frames, while the stream is idle, and drives every byte on the falling clock edge. The predicted hash index comes from a separately written bit-serial model that runs over the whole 48-bit address.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;

  localparam int unsigned ADDR_BYTES = 6;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned ADDR_W     = ADDR_BYTES * BYTE_W;
  localparam int unsigned CRC_W      = 32;
  localparam int unsigned HASH_IDX_W = 6;
  localparam int unsigned HASH_SIZE  = 1 << HASH_IDX_W;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [CRC_W-1:0] CRC_INIT = '1;

  typedef struct packed {
    logic bcast_reject;
    logic promisc;
    logic hash_all;
  } filt_mode_t;

  // One byte through the CRC register, data bit 0 first.
  function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] crc_in,
                                                     input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = crc_in;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return c;
  endfunction

  function automatic logic [HASH_IDX_W-1:0] hash_index(input logic [CRC_W-1:0] crc);
    return crc[CRC_W-1 -: HASH_IDX_W];
  endfunction

endpackage

// File: rtl/dafilt_collect.sv
module dafilt_collect #(
  parameter int unsigned N_BYTES = 6,
  parameter int unsigned B_W     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_sof,
  input  logic                   in_last,
  input  logic [B_W-1:0]         in_data,
  output logic                   take,
  output logic                   decide,
  output logic                   short_frame,
  output logic [N_BYTES*B_W-1:0] addr_full
);
  localparam int unsigned CNT_W = $clog2(N_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(N_BYTES - 1);

  logic             open_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pos;

  assign pos         = in_sof ? '0 : cnt_q;
  assign take        = in_valid && (in_sof || open_q);
  assign decide      = take && ((pos == LAST_POS) || in_last);
  assign short_frame = pos < LAST_POS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else if (take) begin
      open_q <= !decide;
      cnt_q  <= pos + 1'b1;
    end
  end

  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    logic [B_W-1:0] byte_q;
    logic           hit;
    assign hit = take && (pos == CNT_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   byte_q <= '0;
      else if (hit) byte_q <= in_data;
    end
    assign addr_full[(N_BYTES-1-g)*B_W +: B_W] = hit ? in_data : byte_q;
  end

endmodule

// File: rtl/dafilt_crc.sv
module dafilt_crc
  import dafilt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              restart,
  input  logic [BYTE_W-1:0] data,
  output logic [CRC_W-1:0]  crc_next
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_base;

  assign crc_base = restart ? CRC_INIT : crc_q;
  assign crc_next = take ? crc_step_byte(crc_base, data) : crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= CRC_INIT;
    else if (take) crc_q <= crc_next;
  end

endmodule

// File: rtl/dafilt_classify.sv
module dafilt_classify
  import dafilt_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [CRC_W-1:0]  crc,
  input  logic              short_frame,
  input  filt_mode_t        mode,
  input  logic [15:0]       stn_hi,
  input  logic [31:0]       stn_lo,
  input  logic [31:0]       hash_lo,
  input  logic [31:0]       hash_hi,
  output logic              is_bcast,
  output logic              hash_path,
  output logic              hash_hit,
  output logic              exact_hit,
  output logic              miss,
  output logic              accept
);
  logic [HASH_SIZE-1:0]  table_bits;
  logic [HASH_IDX_W-1:0] idx;

  assign table_bits = {hash_hi, hash_lo};
  assign idx        = hash_index(crc);
  assign is_bcast   = &addr;
  assign hash_path  = addr[ADDR_W-BYTE_W] || mode.hash_all;
  assign hash_hit   = table_bits[idx];
  assign exact_hit  = addr == {stn_hi, stn_lo};

  always_comb begin
    if (short_frame)    miss = 1'b1;
    else if (is_bcast)  miss = mode.bcast_reject;
    else if (hash_path) miss = !hash_hit;
    else                miss = !exact_hit;
  end

  assign accept = !miss || mode.promisc;

endmodule

// File: rtl/dafilt_top.sv
module dafilt_top
  import dafilt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_last,
  input  logic [7:0]  in_data,
  input  logic        mode_bcast_reject,
  input  logic        mode_promisc,
  input  logic        mode_hash_all,
  input  logic [15:0] stn_hi,
  input  logic [31:0] stn_lo,
  input  logic [31:0] hash_lo,
  input  logic [31:0] hash_hi,
  output logic        dec_valid,
  output logic        dec_accept,
  output logic        dec_miss
);
  filt_mode_t        mode;
  logic              take_w;
  logic              decide_w;
  logic              short_w;
  logic [ADDR_W-1:0] addr_w;
  logic [CRC_W-1:0]  crc_w;
  logic              bcast_w;
  logic              hash_path_w;
  logic              hash_hit_w;
  logic              exact_hit_w;
  logic              miss_w;
  logic              accept_w;

  assign mode = '{bcast_reject: mode_bcast_reject, promisc: mode_promisc,
                  hash_all: mode_hash_all};

  dafilt_collect #(.N_BYTES(ADDR_BYTES), .B_W(BYTE_W)) u_collect (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_last(in_last), .in_data(in_data), .take(take_w), .decide(decide_w),
    .short_frame(short_w), .addr_full(addr_w)
  );

  dafilt_crc u_crc (
    .clk(clk), .rst_n(rst_n), .take(take_w), .restart(in_sof),
    .data(in_data), .crc_next(crc_w)
  );

  dafilt_classify u_cls (
    .addr(addr_w), .crc(crc_w), .short_frame(short_w), .mode(mode),
    .stn_hi(stn_hi), .stn_lo(stn_lo), .hash_lo(hash_lo), .hash_hi(hash_hi),
    .is_bcast(bcast_w), .hash_path(hash_path_w), .hash_hit(hash_hit_w),
    .exact_hit(exact_hit_w), .miss(miss_w), .accept(accept_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_miss   <= 1'b0;
    end else begin
      dec_valid  <= decide_w;
      dec_accept <= decide_w && accept_w;
      dec_miss   <= decide_w && miss_w;
    end
  end

endmodule

// File: rtl/dafilt_chk.sv
module dafilt_chk (
  input logic clk,
  input logic rst_n,
  input logic decide,
  input logic is_short,
  input logic is_bcast,
  input logic hash_path,
  input logic hash_hit,
  input logic bcast_reject,
  input logic promisc,
  input logic dec_valid,
  input logic dec_accept,
  input logic dec_miss
);
  a_r8_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
    decide |=> dec_valid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !decide |=> !dec_valid);
  a_r8_idle_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!dec_accept && !dec_miss));
  a_r7_accept_rule: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_accept == (!dec_miss || $past(promisc))));
  a_r6_short_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && is_short) |=> dec_miss);
  a_r1_bcast_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && !is_short && is_bcast) |=> (dec_miss == $past(bcast_reject)));
  a_r2_hash_result: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && !is_short && !is_bcast && hash_path) |=> (dec_miss == !$past(hash_hit)));
endmodule

bind dafilt_top dafilt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .decide(decide_w), .is_short(short_w),
  .is_bcast(bcast_w), .hash_path(hash_path_w), .hash_hit(hash_hit_w),
  .bcast_reject(mode_bcast_reject), .promisc(mode_promisc),
  .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_miss(dec_miss)
);

// File: tb/sim_dafilt_top.sv
`timescale 1ns/1ps
module sim_dafilt_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic m_bro = 1'b0, m_pro = 1'b0, m_iam = 1'b0;
  logic [15:0] stn_hi = 16'h0211;
  logic [31:0] stn_lo = 32'h22334455;
  logic [31:0] hash_lo = '0, hash_hi = '0;
  logic dec_valid, dec_accept, dec_miss;

  int checks = 0, errors = 0;
  int pulses = 0;
  logic got_acc = 1'b0, got_miss = 1'b0;

  always #10 clk = ~clk;

  dafilt_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_last(in_last), .in_data(in_data), .mode_bcast_reject(m_bro),
    .mode_promisc(m_pro), .mode_hash_all(m_iam), .stn_hi(stn_hi),
    .stn_lo(stn_lo), .hash_lo(hash_lo), .hash_hi(hash_hi),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_miss(dec_miss)
  );

  always @(negedge clk) begin
    if (dec_valid) begin
      pulses   = pulses + 1;
      got_acc  = dec_accept;
      got_miss = dec_miss;
    end
  end

  // [53:6] dest (first byte in [53:46]), [5] hash fill, [4] bro, [3] pro, [2] iam, [1] accept, [0] miss
  localparam logic [53:0] VEC [12] = '{
    {48'h021122334455, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {48'h021122334456, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {48'h001122334455, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {48'h021122334456, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {48'hFFFFFFFFFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {48'hFFFFFFFFFFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {48'hFFFFFFFFFFFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {48'h01005E000001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {48'h01005E000001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {48'h021122334455, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    {48'h0A0B0C0D0E0F, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {48'hFFFFFFFFFFFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic logic [5:0] ref_index(input logic [47:0] da);
    logic [31:0] r;
    logic b;
    r = 32'hFFFFFFFF;
    for (int k = 0; k < 48; k++) begin
      b = da[47 - 8*(k/8) - 7 + (k%8)];
      if (r[31] ^ b) r = (r << 1) ^ 32'h04C11DB7;
      else           r = r << 1;
    end
    return r[31:26];
  endfunction

  function automatic logic [7:0] byte_of(input logic [47:0] da, input int i);
    if (i < 6) return da[47 - 8*i -: 8];
    return 8'(i * 17);
  endfunction

  task automatic drive(input logic [47:0] da, input int i, input bit sof, input bit last);
    @(negedge clk);
    in_valid = 1'b1; in_sof = sof; in_last = last; in_data = byte_of(da, i);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_last = 1'b0; in_data = 8'h00;
    end
  endtask

  task automatic send(input logic [47:0] da, input int n);
    for (int i = 0; i < n; i++) drive(da, i, i == 0, i == n - 1);
    idle(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int p0;
    logic [5:0] ix;
    logic [63:0] tbl;
    repeat (3) @(negedge clk);
    chk("R10", "valid after reset", dec_valid, 0);
    chk("R10", "accept after reset", dec_accept, 0);
    chk("R10", "miss after reset", dec_miss, 0);
    rst_n = 1'b1;
    idle(2);

    // R1 R2 R3 R4 R7 table
    for (int v = 0; v < 12; v++) begin
      {hash_hi, hash_lo} = VEC[v][5] ? '1 : '0;
      m_bro = VEC[v][4]; m_pro = VEC[v][3]; m_iam = VEC[v][2];
      p0 = pulses;
      send(VEC[v][53:6], 6);
      chk("R1-R4/R7 vector", "pulse count", pulses - p0, 1);
      chk("R7 vector", "accept", got_acc, VEC[v][1]);
      chk("R1 R2 R3 R4 vector", "miss", got_miss, VEC[v][0]);
    end
    m_bro = 0; m_pro = 0; m_iam = 0;

    // R8 timing: pulse in the cycle after the sixth byte, one cycle wide
    for (int i = 0; i < 6; i++) drive(48'h021122334455, i, i == 0, 1'b0);
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    chk("R8", "valid after sixth byte", dec_valid, 1);
    chk("R8", "accept on match", dec_accept, 1);
    @(negedge clk);
    chk("R8", "valid one cycle", dec_valid, 0);
    chk("R8", "flags low when idle", dec_accept | dec_miss, 0);
    idle(2);

    // R8 long frame: one decision only, trailing bytes ignored
    p0 = pulses;
    send(48'h021122334455, 10);
    chk("R8", "long frame pulses", pulses - p0, 1);
    chk("R8", "long frame accept", got_acc, 1);

    // R6 short frame
    p0 = pulses;
    send(48'h021122334455, 3);
    chk("R6", "short pulses", pulses - p0, 1);
    chk("R6", "short miss", got_miss, 1);
    chk("R6", "short accept", got_acc, 0);
    m_pro = 1;
    send(48'hFFFFFFFFFFFF, 1);
    chk("R6", "short promisc miss", got_miss, 1);
    chk("R7", "short promisc accept", got_acc, 1);
    m_pro = 0;

    // R9 restart after a cut frame
    p0 = pulses;
    for (int i = 0; i < 3; i++) drive(48'hFFFFFFFFFFFF, i, i == 0, 1'b0);
    send(48'h021122334455, 6);
    chk("R9", "restart pulses", pulses - p0, 1);
    chk("R9", "restart accept", got_acc, 1);
    chk("R9", "restart miss", got_miss, 0);

    // R9 bytes with no open frame
    p0 = pulses;
    for (int i = 0; i < 8; i++) drive(48'h021122334455, i % 6, 1'b0, i == 7);
    idle(3);
    chk("R9", "orphan bytes pulses", pulses - p0, 0);

    // R5 hash index, two addresses
    for (int a = 0; a < 2; a++) begin
      logic [47:0] da;
      da = (a == 0) ? 48'h01005E0000FB : 48'h333300000001;
      ix = ref_index(da);
      tbl = 64'd1 << ix;
      {hash_hi, hash_lo} = tbl;
      send(da, 6);
      chk("R5", "selected bit hit", got_miss, 0);
      {hash_hi, hash_lo} = ~tbl;
      send(da, 6);
      chk("R5", "selected bit clear", got_miss, 1);
    end
    // R3 with hash-all on an individual address
    m_iam = 1;
    ix = ref_index(48'h0A0B0C0D0E0F);
    {hash_hi, hash_lo} = 64'd1 << ix;
    send(48'h0A0B0C0D0E0F, 6);
    chk("R3", "hash_all indexed hit", got_miss, 0);
    m_iam = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule